// File: doc/BRIEF.md
# Ladder Program Store and Fetch Decoder

This block holds the compiled ladder program as a list of 16-bit words and hands them to a rung evaluation engine one at a time. A loader streams words into the store through a load port. Each load lands at the next free address, so a program is written in order starting from address 0. The engine asks for the next word with a fetch request. The block then reads the word at its read pointer, splits it into a contact kind, an attribute code and an image address, and pulses an execute strobe for one cycle. When the read pointer catches up with the write pointer, the block raises a program-end flag. The next fetch then starts the scan again from address 0.

A second store, one bit wide and 1024 deep, keeps the controller's image. Addresses 0–255 are inputs, 256–511 are outputs and 512–1023 are internal flags. The input region is captured in one cycle from an external input bus. When the engine asks to read the image, the contact status returns the bit at the address in the current word. In every other cycle the coil value is written at the coil address, unless that address falls in the input region.

Top module: `ladder_prog_store`

## Requirements
- R1: While reset is held and in the first cycle after it, exec_strobe is 0, contact_status is 0 and prog_end is 1, because both pointers are at 0. Every image location from 256 to 511 reads 0 after reset.
- R2: Each cycle with load_en high stores load_word at the next address. The addresses run upward from 0 in load order.
- R3: A fetch_req with load_en low, on a non-empty program, makes exec_strobe high in the next cycle for one cycle. The decoded fields then come from the next word in load order.
- R4: The decoded fields are contact_code = word bits 15:13, attr_code = {bit 15, bits 12:10} and io_addr = bits 9:0. Bit 15 therefore appears in both contact_code and attr_code.
- R5: If load_en and fetch_req are high in the same cycle, the load is performed and the fetch is delayed. exec_strobe is 0 in the next cycle and goes high one cycle later.
- R6: prog_end is 1 exactly when the read pointer equals the write pointer. A fetch while prog_end is 1 returns the word at address 0.
- R7: A fetch_req while no word has been loaded since reset is ignored, and exec_strobe stays 0.
- R8: With img_rd high, contact_status takes the image bit at io_addr in the next cycle. With img_rd low, contact_status keeps its value.
- R9: With img_rd low, coil_in is written at coil_addr when coil_addr is 256 or above. A write to an address from 0 to 255 has no effect.
- R10: A cycle with in_capture high copies in_bus bit i into image location i, for i from 0 to 255.
- R11: Reset leaves the input region (0–255) and the flag region (512–1023) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Store load_word at the write pointer |
| load_word | input | 16 | Program word to store |
| fetch_req | input | 1 | Request the next program word |
| exec_strobe | output | 1 | One-cycle pulse: decoded fields are valid |
| contact_code | output | 3 | Contact kind field of the fetched word |
| attr_code | output | 4 | Attribute field of the fetched word |
| io_addr | output | 10 | Image address field of the fetched word |
| prog_end | output | 1 | Read pointer has reached the write pointer |
| in_capture | input | 1 | Copy in_bus into the input region |
| in_bus | input | IN_N (256) | Physical input values |
| img_rd | input | 1 | Read the image bit at io_addr |
| coil_in | input | 1 | Coil result to write |
| coil_addr | input | 10 | Image address for coil_in |
| contact_status | output | 1 | Image bit read last |

## Verification
The assertions watch the fetch handshake in every cycle. They check that the reset state is idle and that a valid fetch always yields a strobe in the next cycle. They also check that no strobe follows a load cycle or appears before anything was loaded, and that contact_status holds whenever no image read happens. Other behaviour needs the bench's scenarios: the exact word order, the field split, the restart from address 0 at program end, and the image contents. For the image, the bench checks that coil writes land in the outputs and flags but not in the inputs, and which regions survive a reset. Those checks need known program and image contents that only a planned sequence provides.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    localparam int WORD_W = 16;
    localparam int KIND_W = 3;
    localparam int ATTR_W = 4;
    localparam int IOA_W  = 10;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ATTR_W-1:0] attr;
        logic [IOA_W-1:0]  ioa;
    } rung_fields_t;

    typedef enum logic {
        FS_IDLE,
        FS_HOLD
    } fetch_st_e;

    // Bit 15 is shared: top of the kind field and top of the attribute field.
    function automatic rung_fields_t split_word(input logic [WORD_W-1:0] w);
        rung_fields_t f;
        f.kind = w[15:13];
        f.attr = {w[15], w[12:10]};
        f.ioa  = w[9:0];
        return f;
    endfunction

endpackage

// File: rtl/lps_fetch_ctrl.sv
module lps_fetch_ctrl
    import ladder_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          fetch_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic          exec_strobe,
    output logic          prog_end
);

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic          exec;
    } fctl_t;

    fctl_t q, d;
    logic          want_rd;
    logic          at_end;
    logic [AW-1:0] next_ra;

    assign at_end  = (q.rptr == q.wptr);
    assign want_rd = fetch_req || (q.st == FS_HOLD);
    assign next_ra = at_end ? '0 : q.rptr;

    always_comb begin
        d         = q;
        d.exec    = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_waddr = q.wptr;
        mem_raddr = next_ra;
        if (load_en) begin
            // loading wins; a read request waits in FS_HOLD
            mem_we = 1'b1;
            d.wptr = q.wptr + 1'b1;
            if (want_rd) begin
                d.st = FS_HOLD;
            end
        end else if (want_rd) begin
            d.st = FS_IDLE;
            if (q.wptr != '0) begin
                mem_re = 1'b1;
                d.rptr = next_ra + 1'b1;
                d.exec = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= FS_IDLE;
            q.wptr <= '0;
            q.rptr <= '0;
            q.exec <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign exec_strobe = q.exec;
    assign prog_end    = at_end;

endmodule

// File: rtl/lps_code_mem.sv
module lps_code_mem #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = re ? store[raddr] : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/lps_io_image.sv
module lps_io_image #(
    parameter int AW    = 10,
    parameter int IN_N  = 256,
    parameter int OUT_N = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_capture,
    input  logic [IN_N-1:0] in_bus,
    input  logic            img_rd,
    input  logic [AW-1:0]   rd_addr,
    input  logic            coil_in,
    input  logic [AW-1:0]   coil_addr,
    output logic            contact_status
);

    localparam int            DEPTH   = 1 << AW;
    localparam int            OUT_LO  = IN_N;
    localparam int            OUT_HI  = IN_N + OUT_N - 1;
    localparam logic [AW-1:0] WR_BASE = AW'(IN_N);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic             cs;
    } img_t;

    img_t q, d;

    always_comb begin
        d = q;
        if (in_capture) begin
            d.bits[IN_N-1:0] = in_bus;
        end
        if (img_rd) begin
            d.cs = q.bits[rd_addr];
        end else if (coil_addr >= WR_BASE) begin
            d.bits[coil_addr] = coil_in;
        end
    end

    // only the output region and the status bit are reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cs                 <= 1'b0;
            q.bits[OUT_HI:OUT_LO] <= '0;
        end else begin
            q <= d;
        end
    end

    assign contact_status = q.cs;

endmodule

// File: rtl/ladder_prog_store.sv
module ladder_prog_store
    import ladder_pkg::*;
#(
    parameter int PROG_AW = 10,
    parameter int IN_N    = 256,
    parameter int OUT_N   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    input  logic              fetch_req,
    output logic              exec_strobe,
    output logic [KIND_W-1:0] contact_code,
    output logic [ATTR_W-1:0] attr_code,
    output logic [IOA_W-1:0]  io_addr,
    output logic              prog_end,
    input  logic              in_capture,
    input  logic [IN_N-1:0]   in_bus,
    input  logic              img_rd,
    input  logic              coil_in,
    input  logic [IOA_W-1:0]  coil_addr,
    output logic              contact_status
);

    logic               mem_we;
    logic               mem_re;
    logic [PROG_AW-1:0] mem_waddr;
    logic [PROG_AW-1:0] mem_raddr;
    logic [WORD_W-1:0]  cur_word;
    rung_fields_t       fields;

    lps_fetch_ctrl #(
        .AW (PROG_AW)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .fetch_req   (fetch_req),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_re      (mem_re),
        .mem_raddr   (mem_raddr),
        .exec_strobe (exec_strobe),
        .prog_end    (prog_end)
    );

    lps_code_mem #(
        .AW (PROG_AW),
        .DW (WORD_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (load_word),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (cur_word)
    );

    assign fields       = split_word(cur_word);
    assign contact_code = fields.kind;
    assign attr_code    = fields.attr;
    assign io_addr      = fields.ioa;

    lps_io_image #(
        .AW    (IOA_W),
        .IN_N  (IN_N),
        .OUT_N (OUT_N)
    ) u_img (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_capture     (in_capture),
        .in_bus         (in_bus),
        .img_rd         (img_rd),
        .rd_addr        (fields.ioa),
        .coil_in        (coil_in),
        .coil_addr      (coil_addr),
        .contact_status (contact_status)
    );

endmodule

// File: rtl/lps_checker.sv
module lps_checker (
    input logic clk,
    input logic rst_n,
    input logic load_en,
    input logic fetch_req,
    input logic exec_strobe,
    input logic img_rd,
    input logic contact_status,
    input logic prog_end
);

    logic loaded_any_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_any_q <= 1'b0;
        end else if (load_en) begin
            loaded_any_q <= 1'b1;
        end
    end

    // R1: first cycle after reset is idle
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!exec_strobe && !contact_status && prog_end));

    // R3: a granted fetch on a loaded program strobes next cycle
    p_fetch_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !load_en && loaded_any_q) |=> exec_strobe);

    // R5: a load cycle never yields a strobe in the following cycle
    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_strobe |-> !$past(load_en));

    // R7: no strobe before anything was loaded
    p_empty_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_strobe |-> loaded_any_q);

    // R8: status holds when no image read is requested
    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !img_rd |=> $stable(contact_status));

endmodule

bind ladder_prog_store lps_checker u_lps_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_en        (load_en),
    .fetch_req      (fetch_req),
    .exec_strobe    (exec_strobe),
    .img_rd         (img_rd),
    .contact_status (contact_status),
    .prog_end       (prog_end)
);

// File: tb/ladder_prog_store_bench.sv
module ladder_prog_store_bench;

    logic         clk;
    logic         rst_n;
    logic         load_en;
    logic [15:0]  load_word;
    logic         fetch_req;
    logic         exec_strobe;
    logic [2:0]   contact_code;
    logic [3:0]   attr_code;
    logic [9:0]   io_addr;
    logic         prog_end;
    logic         in_capture;
    logic [255:0] in_bus;
    logic         img_rd;
    logic         coil_in;
    logic [9:0]   coil_addr;
    logic         contact_status;

    int checks   = 0;
    int failures = 0;

    // {word, expected kind, expected attr, expected io address}
    localparam logic [32:0] VEC [8] = '{
        {16'hAC05, 3'd5, 4'hB, 10'd5},
        {16'h592C, 3'd2, 4'h6, 10'd300},
        {16'hE2BC, 3'd7, 4'h8, 10'd700},
        {16'h1C64, 3'd0, 4'h7, 10'd100},
        {16'hFFFF, 3'd7, 4'hF, 10'd1023},
        {16'h0000, 3'd0, 4'h0, 10'd0},
        {16'h8400, 3'd4, 4'h9, 10'd0},
        {16'h7BFF, 3'd3, 4'h6, 10'd1023}
    };

    ladder_prog_store u_ladder_prog_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_en        (load_en),
        .load_word      (load_word),
        .fetch_req      (fetch_req),
        .exec_strobe    (exec_strobe),
        .contact_code   (contact_code),
        .attr_code      (attr_code),
        .io_addr        (io_addr),
        .prog_end       (prog_end),
        .in_capture     (in_capture),
        .in_bus         (in_bus),
        .img_rd         (img_rd),
        .coil_in        (coil_in),
        .coil_addr      (coil_addr),
        .contact_status (contact_status)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_table();
        for (int i = 0; i < 8; i++) begin
            load_en   = 1'b1;
            load_word = VEC[i][32:17];
            step();
        end
        load_en = 1'b0;
    endtask

    task automatic fetch_and_read();
        fetch_req = 1'b1;
        step();
        fetch_req = 1'b0;
        img_rd    = 1'b1;
        step();
        img_rd    = 1'b0;
    endtask

    task automatic coil_write(input logic [9:0] a, input logic v);
        coil_addr = a;
        coil_in   = v;
        step();
        coil_addr = 10'd1000;
        coil_in   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        load_en    = 1'b0;
        load_word  = '0;
        fetch_req  = 1'b0;
        in_capture = 1'b0;
        in_bus     = '0;
        img_rd     = 1'b0;
        coil_in    = 1'b0;
        coil_addr  = 10'd1000;
        repeat (3) step();
        chk("R1 strobe in reset", exec_strobe, 0);
        chk("R1 status in reset", contact_status, 0);
        rst_n = 1'b1;
        step();
        chk("R1 strobe after reset", exec_strobe, 0);
        chk("R1 prog_end after reset", prog_end, 1);

        // R7: fetch with nothing loaded
        fetch_req = 1'b1;
        step();
        fetch_req = 1'b0;
        chk("R7 empty fetch strobe", exec_strobe, 0);
        step();
        chk("R7 empty fetch later", exec_strobe, 0);

        load_table();
        chk("R6 prog_end after load", prog_end, 0);

        // table walk: R2 order, R3 strobe, R4 fields
        for (int i = 0; i < 8; i++) begin
            fetch_req = 1'b1;
            step();
            fetch_req = 1'b0;
            chk("R3 strobe", exec_strobe, 1);
            chk("R4 contact_code", contact_code, VEC[i][16:14]);
            chk("R4 attr_code", attr_code, VEC[i][13:10]);
            chk("R2 io_addr order", io_addr, VEC[i][9:0]);
            step();
            chk("R3 strobe one cycle", exec_strobe, 0);
        end
        chk("R6 prog_end at end", prog_end, 1);

        fetch_req = 1'b1;
        step();
        fetch_req = 1'b0;
        chk("R6 restart strobe", exec_strobe, 1);
        chk("R6 restart word 0", io_addr, VEC[0][9:0]);
        chk("R6 prog_end cleared", prog_end, 0);

        // R5: load and fetch collide
        load_en   = 1'b1;
        load_word = 16'h1234;
        fetch_req = 1'b1;
        step();
        load_en   = 1'b0;
        fetch_req = 1'b0;
        chk("R5 no strobe on collision", exec_strobe, 0);
        step();
        chk("R5 delayed strobe", exec_strobe, 1);
        chk("R5 delayed word", io_addr, VEC[1][9:0]);
        chk("R5 delayed kind", contact_code, VEC[1][16:14]);

        // image phase
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        step();
        load_table();

        in_bus     = '0;
        in_bus[5]  = 1'b1;
        in_capture = 1'b1;
        step();
        in_capture = 1'b0;

        fetch_and_read();               // word 0, address 5
        chk("R10 captured input", contact_status, 1);
        step();
        chk("R8 status held", contact_status, 1);

        coil_write(10'd300, 1'b1);
        fetch_and_read();               // word 1, address 300
        chk("R9 output written", contact_status, 1);

        coil_write(10'd700, 1'b1);
        coil_write(10'd100, 1'b1);
        fetch_and_read();               // word 2, address 700
        chk("R9 flag written", contact_status, 1);
        fetch_and_read();               // word 3, address 100
        chk("R9 input write ignored", contact_status, 0);

        // second reset: outputs cleared, inputs and flags kept
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        step();
        chk("R1 status cleared", contact_status, 0);
        load_table();
        fetch_and_read();
        chk("R11 input kept", contact_status, 1);
        fetch_and_read();
        chk("R1 output cleared", contact_status, 0);
        fetch_and_read();
        chk("R11 flag kept", contact_status, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule